// File: doc/BRIEF.md
# Auto-Increment Color Palette Port

This block holds a 256-entry color table of 18-bit RGB values (6 bits per component). A host reaches it through a byte-wide register port with four selectable registers: a pixel mask, a write-start index, a read-start index, and one shared data register. A host loads an entry by writing a start index and then three bytes to the data register: red, then green, then blue. After the blue byte the index moves to the next entry on its own, so a whole palette streams in without re-addressing. Reads work the same way through a separate read index and read sequencer.

A second path serves the display pipeline. Each cycle, an 8-bit pixel index is ANDed with the pixel mask and looked up in the table. The RGB result appears on a registered output one clock later. Red and green bytes wait in staging registers, and the table entry is written in one step when blue arrives. The display therefore never sees an entry that is only partly updated.

Top module: `palette_port`

## Requirements
- R1: After reset, the mask register reads 0xFF, both index registers read 0, both component sequencers point at red, and `pix_rgb` is 0.
- R2: A write to register select 1 (write index) loads the write index and returns the write sequencer to red. A write to select 2 (read index) does the same for the read index and the read sequencer. This holds even part-way through a component sequence.
- R3: Writes to select 3 (data) load red, then green, then blue of the entry at the write index. Only bits 5:0 of each byte are kept, and bits 7:6 are ignored.
- R4: The table entry changes only on the blue write. After red and green alone, the lookup path still returns the entry's previous value.
- R5: The write index increments by one when an entry is committed on the blue write, and it wraps from 255 to 0. Red and green writes leave the index unchanged.
- R6: Reads of select 3 return red, then green, then blue of the entry at the read index, zero-extended in bits 5:0. The third read advances the read index by one, wrapping from 255 to 0.
- R7: `pix_rgb` is valid one clock after `pix_idx` and equals the entry at (`pix_idx` AND mask). Red is in bits 17:12, green in 11:6 and blue in 5:0.
- R8: A write to select 0 sets the pixel mask. Only the index bits that are set in the mask select entries, and 0xFF passes every index unchanged.
- R9: `rdata` reflects the register chosen by `sel` in the same cycle: the mask for select 0, the write index for select 1, the read index for select 2, and the current read component for select 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host read strobe (advances the read sequencer on select 3) |
| sel | input | 2 | Register select: 0 mask, 1 write index, 2 read index, 3 data |
| wdata | input | 8 | Host write byte |
| rdata | output | 8 | Host read byte, combinational from `sel` and state |
| pix_idx | input | 8 | Pixel index from the display pipeline |
| pix_rgb | output | 18 | Looked-up color, registered |

## Verification
Host reads are combinational, so `rdata` is sampled in the same cycle that `rd_en` and `sel` are driven, shortly after the falling edge. Any side effect of a read or write on the index and sequencer is taken at the next rising edge. The pixel result is due exactly one rising edge after `pix_idx` is applied, and the bench samples it at the following falling edge. The half-update case looks up an entry between the green write and the blue write, and expects the old contents there.

// File: rtl/palette_port.sv
module palette_port #(
  parameter int IDX_W  = 8,
  parameter int COMP_W = 6,
  parameter int BUS_W  = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [1:0]          sel,
  input  logic [BUS_W-1:0]    wdata,
  output logic [BUS_W-1:0]    rdata,
  input  logic [IDX_W-1:0]    pix_idx,
  output logic [3*COMP_W-1:0] pix_rgb
);
  localparam int ENTRIES = 1 << IDX_W;
  localparam int RGB_W   = 3 * COMP_W;
  localparam logic [1:0] SEL_MASK = 2'd0, SEL_WIDX = 2'd1, SEL_RIDX = 2'd2, SEL_DATA = 2'd3;
  localparam logic [1:0] PH_R = 2'd0, PH_G = 2'd1, PH_B = 2'd2;

  logic [RGB_W-1:0]  lut [ENTRIES];
  logic [IDX_W-1:0]  mask, wr_idx, rd_idx;
  logic [1:0]        wr_ph, rd_ph;
  logic [COMP_W-1:0] stg_r, stg_g, rd_comp;
  logic [RGB_W-1:0]  rd_entry;

  wire data_wr = wr_en && sel == SEL_DATA;
  wire data_rd = rd_en && sel == SEL_DATA;
  wire commit  = data_wr && wr_ph == PH_B;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask   <= '1;
      wr_idx <= '0;
      rd_idx <= '0;
      wr_ph  <= PH_R;
      rd_ph  <= PH_R;
      stg_r  <= '0;
      stg_g  <= '0;
    end else begin
      if (wr_en) begin
        case (sel)
          SEL_MASK: mask <= wdata[IDX_W-1:0];
          SEL_WIDX: begin wr_idx <= wdata[IDX_W-1:0]; wr_ph <= PH_R; end
          SEL_RIDX: begin rd_idx <= wdata[IDX_W-1:0]; rd_ph <= PH_R; end
          default: begin
            case (wr_ph)
              PH_R:    begin stg_r <= wdata[COMP_W-1:0]; wr_ph <= PH_G; end
              PH_G:    begin stg_g <= wdata[COMP_W-1:0]; wr_ph <= PH_B; end
              default: begin wr_idx <= wr_idx + 1'b1;     wr_ph <= PH_R; end
            endcase
          end
        endcase
      end
      if (data_rd && !(wr_en && sel == SEL_RIDX)) begin
        if (rd_ph == PH_B) begin
          rd_ph  <= PH_R;
          rd_idx <= rd_idx + 1'b1;
        end else begin
          rd_ph <= rd_ph + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (commit) lut[wr_idx] <= {stg_r, stg_g, wdata[COMP_W-1:0]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pix_rgb <= '0;
    else        pix_rgb <= lut[pix_idx & mask];
  end

  assign rd_entry = lut[rd_idx];

  always_comb begin
    case (rd_ph)
      PH_R:    rd_comp = rd_entry[RGB_W-1 -: COMP_W];
      PH_G:    rd_comp = rd_entry[2*COMP_W-1 -: COMP_W];
      default: rd_comp = rd_entry[COMP_W-1:0];
    endcase
  end

  always_comb begin
    case (sel)
      SEL_MASK: rdata = BUS_W'(mask);
      SEL_WIDX: rdata = BUS_W'(wr_idx);
      SEL_RIDX: rdata = BUS_W'(rd_idx);
      default:  rdata = BUS_W'(rd_comp);
    endcase
  end
endmodule

module palette_port_chk #(
  parameter int IDX_W = 8,
  parameter int BUS_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic             rd_en,
  input logic [1:0]       sel,
  input logic [BUS_W-1:0] wdata,
  input logic [IDX_W-1:0] mask,
  input logic [IDX_W-1:0] wr_idx,
  input logic [IDX_W-1:0] rd_idx,
  input logic [1:0]       wr_ph,
  input logic [1:0]       rd_ph
);
  // R5
  wr_commit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel == 2'd3 && wr_ph == 2'd2) |=> (wr_idx == $past(wr_idx) + 1'b1 && wr_ph == 2'd0));
  // R5
  wr_partial_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel == 2'd3 && wr_ph != 2'd2) |=> $stable(wr_idx));
  // R2
  wr_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel == 2'd1) |=> (wr_ph == 2'd0 && wr_idx == $past(wdata[IDX_W-1:0])));
  // R6
  rd_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en && sel == 2'd3 && rd_ph == 2'd2) |=> (rd_idx == $past(rd_idx) + 1'b1 && rd_ph == 2'd0));
  // R3
  phase_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ph != 2'd3 && rd_ph != 2'd3));
  // R8
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && sel == 2'd0) |=> $stable(mask));
endmodule

bind palette_port palette_port_chk #(.IDX_W(IDX_W), .BUS_W(BUS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .sel(sel), .wdata(wdata),
  .mask(mask), .wr_idx(wr_idx), .rd_idx(rd_idx), .wr_ph(wr_ph), .rd_ph(rd_ph)
);

// File: tb/sim_palette_port.sv
module sim_palette_port;
  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0;
  logic [1:0] sel = 0;
  logic [7:0] wdata = 0, rdata, pix_idx = 0;
  logic [17:0] pix_rgb;
  int checks = 0, errors = 0;
  bit done = 0;

  logic [17:0] mdl [256];
  logic [7:0]  m_mask = 8'hFF, m_widx = 0, m_ridx = 0;
  int          m_wph = 0, m_rph = 0;
  logic [5:0]  m_r, m_g;

  palette_port u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .sel(sel),
                   .wdata(wdata), .rdata(rdata), .pix_idx(pix_idx), .pix_rgb(pix_rgb));

  always #5 clk = ~clk;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [17:0] exp_pix(logic [7:0] idx);
    return mdl[idx & m_mask];
  endfunction

  function automatic logic [7:0] exp_comp(logic [7:0] idx, int ph);
    logic [17:0] e = mdl[idx];
    return ph == 0 ? {2'b0, e[17:12]} : ph == 1 ? {2'b0, e[11:6]} : {2'b0, e[5:0]};
  endfunction

  task automatic bwr(logic [1:0] s, logic [7:0] d);
    @(negedge clk); wr_en = 1; sel = s; wdata = d;
    @(negedge clk); wr_en = 0;
    case (s)
      2'd0: m_mask = d;
      2'd1: begin m_widx = d; m_wph = 0; end
      2'd2: begin m_ridx = d; m_rph = 0; end
      default: begin
        if (m_wph == 0) begin m_r = d[5:0]; m_wph = 1; end
        else if (m_wph == 1) begin m_g = d[5:0]; m_wph = 2; end
        else begin mdl[m_widx] = {m_r, m_g, d[5:0]}; m_widx++; m_wph = 0; end
      end
    endcase
  endtask

  task automatic brd(logic [1:0] s, output logic [7:0] v);
    @(negedge clk); rd_en = 1; sel = s; #1 v = rdata;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic rd_data(string req);
    logic [7:0] v;
    brd(2'd3, v);
    chk(req, v, exp_comp(m_ridx, m_rph));
    if (m_rph == 2) begin m_rph = 0; m_ridx++; end else m_rph++;
  endtask

  task automatic look(string req, logic [7:0] idx);
    @(negedge clk); pix_idx = idx;
    @(negedge clk);
    chk(req, pix_rgb, exp_pix(idx));
  endtask

  initial begin
    logic [7:0] v;
    void'($urandom(32'h1234_5eed));
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    brd(2'd0, v); chk("R1 mask", v, 8'hFF);
    brd(2'd1, v); chk("R1 widx", v, 0);
    brd(2'd2, v); chk("R1 ridx", v, 0);
    chk("R1 pix", pix_rgb, 0);

    // R3 R5 fill entire table, including top bits that must be dropped
    bwr(2'd1, 8'd0);
    for (int i = 0; i < 768; i++) bwr(2'd3, 8'($urandom));
    brd(2'd1, v); chk("R5 wrap to 0", v, 0);
    bwr(2'd1, 8'd254);
    bwr(2'd3, 8'hFF); brd(2'd1, v); chk("R5 hold after red", v, 254);
    bwr(2'd3, 8'hC1); brd(2'd1, v); chk("R5 hold after green", v, 254);
    bwr(2'd3, 8'h80); brd(2'd1, v); chk("R5 step", v, 255);
    look("R3 bits 7:6 ignored", 8'd254);

    // R6 readback with wrap
    bwr(2'd2, 8'd250);
    for (int i = 0; i < 30; i++) rd_data("R6 read sequence");
    brd(2'd2, v); chk("R6 ridx wrap", v, 4);

    // R9 readback of data port does not advance without rd_en use
    @(negedge clk); sel = 2'd3; #1 chk("R9 peek", rdata, exp_comp(m_ridx, m_rph));

    // R7 lookup with full mask
    for (int i = 0; i < 40; i++) look("R7 lookup", 8'($urandom));
    look("R7 idx 0", 8'd0); look("R7 idx 255", 8'd255);

    // R8 masks
    bwr(2'd0, 8'h0F); brd(2'd0, v); chk("R8 mask read", v, 8'h0F);
    for (int i = 0; i < 20; i++) look("R8 masked", 8'($urandom));
    bwr(2'd0, 8'h00); look("R8 zero mask", 8'hAB);
    bwr(2'd0, 8'hFF);

    // R2 restart mid-sequence
    bwr(2'd1, 8'd5); bwr(2'd3, 8'h11);
    bwr(2'd1, 8'd7); bwr(2'd3, 8'h21); bwr(2'd3, 8'h22); bwr(2'd3, 8'h23);
    look("R2 restart entry7", 8'd7); look("R2 entry5 kept", 8'd5);
    bwr(2'd2, 8'd7); rd_data("R2 read restart"); bwr(2'd2, 8'd7); rd_data("R2 read restart");

    // R4 no half-updated entry
    bwr(2'd1, 8'd9); bwr(2'd3, 8'h3F); bwr(2'd3, 8'h2A);
    look("R4 old after green", 8'd9);
    bwr(2'd3, 8'h15); look("R4 new after blue", 8'd9);

    // random mixed traffic
    for (int i = 0; i < 3000; i++) begin
      int op = $urandom_range(0, 9);
      if (op < 4) bwr(2'd3, 8'($urandom));
      else if (op == 4) bwr(2'd1, 8'($urandom));
      else if (op == 5) bwr(2'd2, 8'($urandom));
      else if (op == 6) bwr(2'd0, ($urandom_range(0, 3) == 0) ? 8'($urandom) : 8'hFF);
      else if (op == 7) rd_data("R6 random read");
      else if (op == 8) look("R7 random lookup", 8'($urandom));
      else begin brd(2'd1, v); chk("R9 widx", v, m_widx); end
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule